// File: doc/BRIEF.md
# Burst Controller for a Serially Addressed Static RAM

This block drives an asynchronous 512K x 8 static RAM whose address pins are split in two. The upper 16 address bits come from a pair of chained 8-bit serial-in, parallel-out registers that have an output latch. The lowest 3 bits are driven directly by the controller. A client asks for an 8-byte burst, either a read or a write, at a 16-bit block address. The controller steps the low address through the 8 bytes of that block and produces the active-low write, output and chip enables.

The block serialises a new upper address on a data line plus a clock, then copies it to the address pins with a single latch pulse. With each request the client may name the block it expects to use next. The controller shifts that block into the registers while the current burst runs. A later request for that block then costs only the latch pulse. A request for a block that is neither latched nor staged waits until a full 16-bit shift has completed.

Top module: `serAddrSramCtl`

## Requirements
- R1: The byte moved in slot k (k = 0..7) of a burst at block B sits at the 19-bit memory address {B, k}: B drives address bits 18..3 through the latch and k drives `addrLow`.
- R2: A write burst stores byte k of `wrData` (bits 8k+7..8k) at slot k, with exactly one low cycle of `weN` per byte.
- R3: A read burst returns the byte at slot k in bits 8k+7..8k of `rdData`, valid while `ack` is high.
- R4: A block address leaves on `serData` MSB first, one bit per rising edge of `serClk`, 16 edges per address. `latchStb` pulses high only while `serClk` is low and neither strobe is active.
- R5: `weN` and `oeN` are never low together. `ceN` is low exactly when one of them is low.
- R6: `dqOe` is high only while `weN` is low. In the cycle before `oeN` falls, `dqOe` is low.
- R7: `ack` is a single-cycle pulse after the eighth byte.
- R8: A request for the block already latched starts its burst with no shift and no latch pulse. A write acknowledges 17 cycles after the request is raised, and a read 18 cycles after, because a read adds one bus-turnaround cycle.
- R9: If the block named in `nextBlock` has been shifted during an earlier burst, a later request for it adds only one latch cycle. A write then acknowledges after 18 cycles, with no `serClk` edge.
- R10: A request for any other block waits for a complete 16-bit shift and then a latch cycle. It acknowledges no sooner than 49 cycles after the request.
- R11: During reset `weN`, `oeN` and `ceN` are high, and `dqOe`, `latchStb`, `serClk` and `ack` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Burst request, held until `ack` |
| reqWrite | input | 1 | 1 = write burst, 0 = read burst |
| reqBlock | input | 16 | Block address of the request |
| wrData | input | 64 | Write bytes, slot k in bits 8k+7..8k |
| nextValid | input | 1 | `nextBlock` is a hint worth preloading |
| nextBlock | input | 16 | Block expected for the following request |
| ack | output | 1 | Burst complete |
| rdData | output | 64 | Read bytes, slot k in bits 8k+7..8k |
| serData | output | 1 | Serial address bit |
| serClk | output | 1 | Serial shift clock |
| latchStb | output | 1 | Transfers shifted address to the address pins |
| addrLow | output | 3 | Direct low address bits |
| weN | output | 1 | Write enable, active low |
| oeN | output | 1 | Output enable, active low |
| ceN | output | 1 | Chip enable, active low |
| dqOut | output | 8 | Data to the memory |
| dqOe | output | 1 | Drive enable for `dqOut` |
| dqIn | input | 8 | Data from the memory |

## Verification
The bench issues bursts in three address situations: the block is already latched, it was staged by the hint during an earlier burst, or it is cold. Latency and the count of serial clock edges separate these three paths, because each path has its own cycle cost. The data patterns are a counting byte sequence, all ones, alternating 0x55/0xAA and their mix across blocks 0x0000, 0xFFFF, 0x8001 and 0x1234. A byte or bit swap in slot ordering or in the serial order would show up as wrong read-back. Reads that follow writes test the turnaround between driving and releasing the bus. Reads of the cold blocks 0xFFFF and 0x1234 show that the MSB-first shift reached the latched address.

// File: rtl/serAddrSramPkg.sv
package serAddrSramPkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LATCH,
    ST_TURN,
    ST_BURST,
    ST_ACK
  } ctlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic weLow;
    logic oeLow;
    logic capture;
    logic latch;
    logic loadShift;
    logic selNext;
  } strobe_t;
endpackage

// File: rtl/serAddrSramDp.sv
module serAddrSramDp
  import serAddrSramPkg::*;
#(
  parameter int BLKW  = 16,
  parameter int DW    = 8,
  parameter int NBYTE = 8,
  localparam int IDXW = $clog2(NBYTE),
  localparam int CNTW = $clog2(BLKW) + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic [IDXW-1:0]     idx,
  input  logic [BLKW-1:0]     reqBlock,
  input  logic [BLKW-1:0]     nextBlock,
  input  logic [NBYTE*DW-1:0] wrData,
  output logic [NBYTE*DW-1:0] rdData,
  output logic                shBusy,
  output logic                serData,
  output logic                serClk,
  output logic                latchStb,
  output logic [IDXW-1:0]     addrLow,
  output logic                weN,
  output logic                oeN,
  output logic                ceN,
  output logic [DW-1:0]       dqOut,
  output logic                dqOe,
  input  logic [DW-1:0]       dqIn
);
  logic [BLKW-1:0] shReg;
  logic [CNTW-1:0] bitCnt;
  logic            shPhase;
  logic            serClkR;

  // serial address shifter: each bit takes a low and a high clock phase
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg   <= '0;
      bitCnt  <= '0;
      shPhase <= 1'b0;
      serClkR <= 1'b0;
    end else if (stb.loadShift) begin
      shReg   <= stb.selNext ? nextBlock : reqBlock;
      bitCnt  <= CNTW'(BLKW);
      shPhase <= 1'b0;
      serClkR <= 1'b0;
    end else if (bitCnt != '0) begin
      if (!shPhase) begin
        serClkR <= 1'b1;
        shPhase <= 1'b1;
      end else begin
        serClkR <= 1'b0;
        shPhase <= 1'b0;
        shReg   <= {shReg[BLKW-2:0], 1'b0};
        bitCnt  <= bitCnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else if (stb.capture) rdData[idx*DW +: DW] <= dqIn;
  end

  assign shBusy   = (bitCnt != '0);
  assign serData  = shReg[BLKW-1];
  assign serClk   = serClkR;
  assign latchStb = stb.latch;
  assign addrLow  = idx;
  assign weN      = ~stb.weLow;
  assign oeN      = ~stb.oeLow;
  assign ceN      = weN & oeN;
  assign dqOe     = stb.weLow;
  assign dqOut    = wrData[idx*DW +: DW];
endmodule

// File: rtl/serAddrSramFsm.sv
module serAddrSramFsm
  import serAddrSramPkg::*;
#(
  parameter int BLKW  = 16,
  parameter int NBYTE = 8,
  localparam int IDXW = $clog2(NBYTE)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic            reqWrite,
  input  logic [BLKW-1:0] reqBlock,
  input  logic            nextValid,
  input  logic [BLKW-1:0] nextBlock,
  input  logic            shBusy,
  output strobe_t         stb,
  output logic [IDXW-1:0] idx,
  output logic            ack
);
  ctlState_t       state, stateNxt;
  logic [IDXW-1:0] cnt;
  logic            phase;
  logic            opWrite;
  logic [BLKW-1:0] latchedBlk, stagedBlk;
  logic            latchedValid, stagedSet;
  logic            hit, stagedMatch, nextMatch;

  always_comb begin
    hit         = latchedValid && (reqBlock == latchedBlk);
    stagedMatch = stagedSet && (stagedBlk == reqBlock);
    nextMatch   = stagedSet && (stagedBlk == nextBlock);
    stateNxt    = state;
    stb         = '0;
    case (state)
      ST_IDLE: if (reqValid) begin
        if (hit) stateNxt = reqWrite ? ST_BURST : ST_TURN;
        else if (stagedMatch && !shBusy) stateNxt = ST_LATCH;
        else if (!stagedMatch && !shBusy) stb.loadShift = 1'b1;
      end
      ST_LATCH: begin
        stb.latch = 1'b1;
        stateNxt  = opWrite ? ST_BURST : ST_TURN;
      end
      ST_TURN: stateNxt = ST_BURST;
      ST_BURST: begin
        stb.weLow   = opWrite && !phase;
        stb.oeLow   = !opWrite && !phase;
        stb.capture = !opWrite && !phase;
        // preload the hinted block while this burst runs
        if (nextValid && !shBusy && (nextBlock != latchedBlk) && !nextMatch) begin
          stb.loadShift = 1'b1;
          stb.selNext   = 1'b1;
        end
        if (phase && cnt == IDXW'(NBYTE - 1)) stateNxt = ST_ACK;
      end
      ST_ACK:  stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      cnt          <= '0;
      phase        <= 1'b0;
      opWrite      <= 1'b0;
      latchedBlk   <= '0;
      latchedValid <= 1'b0;
      stagedBlk    <= '0;
      stagedSet    <= 1'b0;
    end else begin
      state <= stateNxt;
      if (state == ST_IDLE) opWrite <= reqWrite;
      if (state != ST_BURST) begin
        cnt   <= '0;
        phase <= 1'b0;
      end else begin
        phase <= ~phase;
        if (phase) cnt <= cnt + 1'b1;
      end
      if (stb.loadShift) begin
        stagedBlk <= stb.selNext ? nextBlock : reqBlock;
        stagedSet <= 1'b1;
      end
      if (stb.latch) begin
        latchedBlk   <= stagedBlk;
        latchedValid <= 1'b1;
        stagedSet    <= 1'b0;
      end
    end
  end

  assign idx = cnt;
  assign ack = (state == ST_ACK);
endmodule

// File: rtl/serAddrSramCtl.sv
module serAddrSramCtl
  import serAddrSramPkg::*;
#(
  parameter int BLKW  = 16,
  parameter int DW    = 8,
  parameter int NBYTE = 8,
  localparam int IDXW = $clog2(NBYTE)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic [BLKW-1:0]     reqBlock,
  input  logic [NBYTE*DW-1:0] wrData,
  input  logic                nextValid,
  input  logic [BLKW-1:0]     nextBlock,
  output logic                ack,
  output logic [NBYTE*DW-1:0] rdData,
  output logic                serData,
  output logic                serClk,
  output logic                latchStb,
  output logic [IDXW-1:0]     addrLow,
  output logic                weN,
  output logic                oeN,
  output logic                ceN,
  output logic [DW-1:0]       dqOut,
  output logic                dqOe,
  input  logic [DW-1:0]       dqIn
);
  strobe_t         stb;
  logic [IDXW-1:0] idx;
  logic            shBusy;

  serAddrSramFsm #(.BLKW(BLKW), .NBYTE(NBYTE)) uFsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqBlock(reqBlock), .nextValid(nextValid), .nextBlock(nextBlock),
    .shBusy(shBusy), .stb(stb), .idx(idx), .ack(ack)
  );

  serAddrSramDp #(.BLKW(BLKW), .DW(DW), .NBYTE(NBYTE)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .idx(idx), .reqBlock(reqBlock),
    .nextBlock(nextBlock), .wrData(wrData), .rdData(rdData), .shBusy(shBusy),
    .serData(serData), .serClk(serClk), .latchStb(latchStb), .addrLow(addrLow),
    .weN(weN), .oeN(oeN), .ceN(ceN), .dqOut(dqOut), .dqOe(dqOe), .dqIn(dqIn)
  );
endmodule

// File: rtl/serAddrSramChk.sv
module serAddrSramChk #(
  parameter int IDXW = 3
) (
  input logic            clk,
  input logic            rstN,
  input logic            weN,
  input logic            oeN,
  input logic            dqOe,
  input logic            ack,
  input logic            latchStb,
  input logic            serClk,
  input logic [IDXW-1:0] addrLow
);
  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN) !(!weN && !oeN));
  // R6
  drive_only_write_chk: assert property (@(posedge clk) disable iff (!rstN) dqOe |-> !weN);
  // R6
  turnaround_chk: assert property (@(posedge clk) disable iff (!rstN) $fell(oeN) |-> !$past(dqOe));
  // R7
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) ack |=> !ack);
  // R4
  latch_quiet_chk: assert property (@(posedge clk) disable iff (!rstN) latchStb |-> (!serClk && weN && oeN));
  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN) !weN |=> (addrLow == $past(addrLow)));
endmodule

bind serAddrSramCtl serAddrSramChk #(.IDXW(IDXW)) uChk (
  .clk(clk), .rstN(rstN), .weN(weN), .oeN(oeN), .dqOe(dqOe), .ack(ack),
  .latchStb(latchStb), .serClk(serClk), .addrLow(addrLow)
);

// File: tb/sim_serAddrSramCtl.sv
module sim_serAddrSramCtl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, nextValid = 1'b0;
  logic [15:0] reqBlock = '0, nextBlock = '0;
  logic [63:0] wrData = '0;
  logic        ack, serData, serClk, latchStb, weN, oeN, ceN, dqOe;
  logic [63:0] rdData;
  logic [2:0]  addrLow;
  logic [7:0]  dqOut, dqIn;

  always #(CLK_PERIOD/2) clk = ~clk;

  serAddrSramCtl u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqBlock(reqBlock), .wrData(wrData), .nextValid(nextValid),
    .nextBlock(nextBlock), .ack(ack), .rdData(rdData), .serData(serData),
    .serClk(serClk), .latchStb(latchStb), .addrLow(addrLow), .weN(weN),
    .oeN(oeN), .ceN(ceN), .dqOut(dqOut), .dqOe(dqOe), .dqIn(dqIn)
  );

  int tests = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural shift registers, latch and byte array
  logic [7:0]  memModel [int];
  logic [7:0]  refMem [int];
  logic [15:0] shModel = '0, upperModel = '0;
  logic [7:0]  dqModel = '0;
  int          serEdges = 0;

  function automatic logic [7:0] rdByte(input int a);
    return memModel.exists(a) ? memModel[a] : 8'h00;
  endfunction

  always @(posedge serClk) begin
    shModel = {shModel[14:0], serData};
    serEdges++;
  end
  always @(posedge latchStb) upperModel = shModel;
  always @(negedge clk) begin
    if (!weN && !ceN && dqOe) memModel[int'({upperModel, addrLow})] = dqOut;
    dqModel = (!oeN && !ceN) ? rdByte(int'({upperModel, addrLow})) : 8'h00;
  end
  assign dqIn = dqModel;

  // scoreboard
  typedef struct {
    bit          isRead;
    logic [15:0] blk;
    logic [63:0] data;
  } item_t;
  item_t sbq[$];
  item_t monItem;
  int    protoErr = 0, turnErr = 0, ackErr = 0;
  logic  prevOeN = 1'b1, prevDqOe = 1'b0, prevAck = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if (ack && !prevAck) begin
        if (sbq.size() == 0) chk(1'b0, "R7", "ack with nothing pending", 64'd1, 64'd0);
        else begin
          monItem = sbq.pop_front();
          if (monItem.isRead) chk(rdData == monItem.data, "R3", "read burst data", rdData, monItem.data);
          else begin
            logic [63:0] got;
            for (int k = 0; k < 8; k++) got[k*8 +: 8] = rdByte(int'({monItem.blk, 3'(k)}));
            chk(got == monItem.data, "R2", "written bytes in memory", got, monItem.data);
          end
        end
      end
      if (!weN && !oeN) protoErr++;
      if (ceN != (weN && oeN)) protoErr++;
      if (dqOe && weN) turnErr++;
      if (prevOeN && !oeN && prevDqOe) turnErr++;
      if (ack && prevAck) ackErr++;
      prevOeN  = oeN;
      prevDqOe = dqOe;
      prevAck  = ack;
    end
  end

  function automatic logic [63:0] refRead(input logic [15:0] blk);
    logic [63:0] v;
    for (int k = 0; k < 8; k++) begin
      int a = int'({blk, 3'(k)});
      v[k*8 +: 8] = refMem.exists(a) ? refMem[a] : 8'h00;
    end
    return v;
  endfunction

  task automatic burst(input bit wr, input logic [15:0] blk, input logic [63:0] d,
                       input bit nv, input logic [15:0] nb, output int lat, output int edges);
    item_t it;
    it.isRead = !wr;
    it.blk    = blk;
    if (wr) for (int k = 0; k < 8; k++) refMem[int'({blk, 3'(k)})] = d[k*8 +: 8];
    it.data = wr ? d : refRead(blk);
    sbq.push_back(it);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqBlock = blk; wrData = d;
    nextValid = nv; nextBlock = nb;
    serEdges = 0;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!ack && lat < 500);
    edges = serEdges;
    reqValid = 1'b0;
    nextValid = 1'b0;
    @(negedge clk);
    chk(!ack, "R7", "ack lasts one cycle", 64'(ack), 64'd0);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  localparam logic [63:0] D1 = 64'h0706050403020100;
  localparam logic [63:0] D2 = 64'hFFFFFFFFFFFFFFFF;
  localparam logic [63:0] D3 = 64'h55AA55AA55AA55AA;
  localparam logic [63:0] D4 = 64'hA5C3E1F00F1E3C5A;
  localparam logic [63:0] D5 = 64'h8000000000000001;

  initial begin
    int lat, edges;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(weN && oeN && ceN, "R11", "strobes idle in reset", {weN, oeN, ceN}, 3'b111);
    chk(!dqOe && !latchStb && !serClk && !ack, "R11", "outputs low in reset",
        {dqOe, latchStb, serClk, ack}, 4'b0000);
    @(negedge clk) rstN = 1'b1;

    // cold write, with a hint for 8001
    burst(1'b1, 16'h1234, D1, 1'b1, 16'h8001, lat, edges);
    chk(lat >= 49, "R10", "cold block latency", lat, 49);
    chk(upperModel == 16'h1234, "R4", "latched upper address", upperModel, 16'h1234);
    chk(rdByte(int'({16'h1234, 3'd5})) == 8'h05, "R1", "byte at slot 5",
        rdByte(int'({16'h1234, 3'd5})), 8'h05);
    repeat (40) @(negedge clk);

    // staged block: latch only
    burst(1'b1, 16'h8001, D2, 1'b0, 16'h0, lat, edges);
    chk(lat == 18, "R9", "staged block latency", lat, 18);
    chk(edges == 0, "R9", "no serial clocks for staged block", edges, 0);

    // latched block hits
    burst(1'b0, 16'h8001, '0, 1'b0, 16'h0, lat, edges);
    chk(lat == 18, "R8", "read hit latency with turnaround", lat, 18);
    chk(edges == 0, "R8", "no serial clocks on hit", edges, 0);
    burst(1'b1, 16'h8001, D3, 1'b0, 16'h0, lat, edges);
    chk(lat == 17, "R8", "write hit latency", lat, 17);

    // cold read back of first block
    burst(1'b0, 16'h1234, '0, 1'b0, 16'h0, lat, edges);
    chk(lat >= 49, "R10", "cold read latency", lat, 49);

    burst(1'b1, 16'hFFFF, D4, 1'b1, 16'h0000, lat, edges);
    chk(upperModel == 16'hFFFF, "R4", "latched all-ones address", upperModel, 16'hFFFF);
    repeat (40) @(negedge clk);
    burst(1'b1, 16'h0000, D5, 1'b0, 16'h0, lat, edges);
    chk(lat == 18, "R9", "staged zero block latency", lat, 18);
    burst(1'b0, 16'h0000, '0, 1'b0, 16'h0, lat, edges);
    burst(1'b0, 16'hFFFF, '0, 1'b0, 16'h0, lat, edges);
    burst(1'b0, 16'h8001, '0, 1'b0, 16'h0, lat, edges);
    chk(rdByte(int'({16'h0000, 3'd0})) == 8'h01 && rdByte(int'({16'h0000, 3'd7})) == 8'h80,
        "R1", "slot order in block 0", rdByte(int'({16'h0000, 3'd7})), 8'h80);

    repeat (5) @(negedge clk);
    chk(protoErr == 0, "R5", "strobe exclusivity and chip enable", protoErr, 0);
    chk(turnErr == 0, "R6", "bus drive and turnaround", turnErr, 0);
    chk(ackErr == 0, "R7", "ack pulse width", ackErr, 0);
    chk(sbq.size() == 0, "R3", "all bursts acknowledged", sbq.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule